// File: doc/BRIEF.md
# Pipelined ADC Stage-Code Corrector

This block sits on the digital side of a pipelined analog-to-digital converter. Four coarse stages each hand it a 3-bit code, and a final 4-bit flash stage hands it the finest code. Only two bits of each coarse code carry weight. The third bit is redundancy, which lets a later stage absorb a decision error made by an earlier comparator. For any one sample the stages report one clock apart. The first coarse stage reports first and the flash stage reports four cycles after it.

The block delays each coarse code so that all five codes of a sample meet in the same cycle. It then adds them with weights that step by a factor of four, removes the per-stage offset that the redundancy introduces, and limits the result to the output range. The result is registered with a valid flag. That flag is the input valid flag, delayed through the same path.

Top module: `pipe_adc_corrector`

## Requirements
- R1: For sample n, the bench drives coarse stage k (k = 1..4) in cycle n+k-1 and the flash code in cycle n+4. These five staggered codes combine into a single output word. Stage k's code is carried on `stage_codes` bits [3k-1:3k-3], so stage 1 is in [2:0] and stage 4 is in [11:9].
- R2: The output word is the clamped value of 256·c1 + 64·c2 + 16·c3 + 4·c4 + f − 340. Here c1..c4 are the coarse codes, f is the flash code, and 340 is one LSB of each coarse stage's weight.
- R3: When the corrected value is negative, the word is 0.
- R4: When the corrected value exceeds 2^OUT_W − 1, the word is all ones. With OUT_W = 11 this is reachable: all coarse codes at 7 with f = 15 gives 2055, so the word is 2047.
- R5: The word for a sample whose first coarse code is driven in cycle n is presented in cycle n+5.
- R6: `word_valid` in cycle n+5 equals `in_valid` in cycle n.
- R7: A synchronous reset discards every sample in flight. After reset is released with all-zero inputs, no earlier sample reaches the output: the word stays 0 and `word_valid` stays low.
- R8: While reset is applied, the word is 0 and `word_valid` is low from the first clock edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a sample whose first coarse code is on `stage_codes` this cycle |
| stage_codes | input | STAGES*CODE_W | Coarse stage codes; stage 1 in the lowest field |
| fine_code | input | FINE_W | Flash stage code for the sample that started four cycles earlier |
| word | output | OUT_W | Corrected, range-limited conversion result |
| word_valid | output | 1 | Qualifies `word` |

## Verification
Two things can happen in the same cycle: the stagger alignment, which pulls fields from five different samples, and the range limiting at the floor or the ceiling. The bench provokes this by streaming every one of the 65536 combinations of the five codes back to back. Each cycle therefore carries codes from neighbouring samples, and many of those samples clamp to zero or saturate. Two instances receive the same stream, one 12 bits wide and one 11 bits wide, so the ceiling is actually reached. Each word is compared against the weighted sum computed arithmetically for its own sample. A reset that lands on samples still in flight is judged by watching the words that follow it.

// File: rtl/pipe_adc_corrector.sv
module pipe_adc_corrector #(
  parameter int STAGES = 4,
  parameter int CODE_W = 3,
  parameter int FINE_W = 4,
  parameter int OUT_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [STAGES*CODE_W-1:0] stage_codes,
  input  logic [FINE_W-1:0]        fine_code,
  output logic [OUT_W-1:0]         word,
  output logic                     word_valid
);
  localparam int STEP   = CODE_W - 1;
  localparam int BASE   = FINE_W - STEP;
  localparam int TOP_SH = BASE + STEP * (STAGES - 1);
  localparam int RAW_W  = TOP_SH + CODE_W + 2;
  localparam int SUM_W  = (RAW_W > OUT_W + 1) ? RAW_W : OUT_W + 2;

  logic [CODE_W-1:0] aligned [STAGES];
  logic [STAGES-1:0] vld_q;
  logic [SUM_W-1:0]  sum;
  logic [OUT_W-1:0]  limited;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      localparam int DEPTH = STAGES - g;
      logic [CODE_W-1:0] dly [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int j = 0; j < DEPTH; j++) dly[j] <= '0;
        end else begin
          dly[0] <= stage_codes[g*CODE_W +: CODE_W];
          for (int j = 1; j < DEPTH; j++) dly[j] <= dly[j-1];
        end
      end
      assign aligned[g] = dly[DEPTH-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[STAGES-2:0], in_valid};
  end

  always_comb begin
    sum = SUM_W'(fine_code);
    for (int k = 0; k < STAGES; k++)
      sum = sum + ((SUM_W'(aligned[k]) - SUM_W'(1)) << (BASE + STEP * (STAGES - 1 - k)));
  end

  assign limited = sum[SUM_W-1]             ? '0 :
                   (|sum[SUM_W-2:OUT_W])    ? '1 :
                                              sum[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      word       <= '0;
      word_valid <= 1'b0;
    end else begin
      word       <= limited;
      word_valid <= vld_q[STAGES-1];
    end
  end
endmodule

module pipe_adc_corrector_chk #(
  parameter int STAGES = 4,
  parameter int CODE_W = 3,
  parameter int FINE_W = 4,
  parameter int OUT_W  = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic [STAGES*CODE_W-1:0] stage_codes,
  input logic [FINE_W-1:0]        fine_code,
  input logic [OUT_W-1:0]         word,
  input logic                     word_valid
);
  localparam int STEP = CODE_W - 1;
  localparam int BASE = FINE_W - STEP;

  function automatic int offs_sum();
    int s = 0;
    for (int k = 0; k < STAGES; k++) s += 1 << (BASE + STEP * (STAGES - 1 - k));
    return s;
  endfunction

  localparam int OFFS     = offs_sum();
  localparam int FULL_RAW = ((1 << CODE_W) - 2) * OFFS + (1 << FINE_W) - 1;
  localparam int OUT_MAX  = (1 << OUT_W) - 1;
  localparam int FULL     = (FULL_RAW > OUT_MAX) ? OUT_MAX : FULL_RAW;
  localparam logic [CODE_W-1:0] CMAX = '1;
  localparam logic [FINE_W-1:0] FMAX = '1;

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  AST_RESET_CLEARS_OUT: assert property (@(posedge clk)
    rst |=> (!word_valid && word == '0)); // R8

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5) |-> (word_valid == $past(in_valid, 5))); // R6

  AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5 && $past(stage_codes[0 +: CODE_W], 5) == '0
                       && $past(stage_codes[CODE_W +: CODE_W], 4) == '0)
    |-> (word == '0)); // R3

  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd5 && $past(stage_codes[0 +: CODE_W], 5) == CMAX
                       && $past(stage_codes[CODE_W +: CODE_W], 4) == CMAX
                       && $past(stage_codes[2*CODE_W +: CODE_W], 3) == CMAX
                       && $past(stage_codes[3*CODE_W +: CODE_W], 2) == CMAX
                       && $past(fine_code, 1) == FMAX)
    |-> (int'(word) == FULL)); // R4
endmodule

bind pipe_adc_corrector pipe_adc_corrector_chk #(
  .STAGES(STAGES), .CODE_W(CODE_W), .FINE_W(FINE_W), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .stage_codes(stage_codes),
  .fine_code(fine_code), .word(word), .word_valid(word_valid)
);

// File: tb/pipe_adc_corrector_bench.sv
module pipe_adc_corrector_bench;
  localparam int N = 65536;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [11:0] stage_codes = '0;
  logic [3:0]  fine_code = '0;
  logic [11:0] word_w;
  logic        valid_w;
  logic [10:0] word_n;
  logic        valid_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  pipe_adc_corrector u_pipe_adc_corrector (
    .clk(clk), .rst(rst), .in_valid(in_valid), .stage_codes(stage_codes),
    .fine_code(fine_code), .word(word_w), .word_valid(valid_w)
  );

  pipe_adc_corrector #(.OUT_W(11)) u_narrow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .stage_codes(stage_codes),
    .fine_code(fine_code), .word(word_n), .word_valid(valid_n)
  );

  function automatic int field(int n, int k);
    if (n < 0 || n >= N) return 0;
    if (k == 4) return (n >> 12) & 15;
    return (n >> (3 * k)) & 7;
  endfunction

  function automatic bit valid_of(int n);
    return (n >= 0 && n < N && (n % 7) != 3);
  endfunction

  function automatic int raw_of(int n);
    return 256 * field(n, 0) + 64 * field(n, 1) + 16 * field(n, 2)
         + 4 * field(n, 3) + field(n, 4) - 340;
  endfunction

  function automatic int limit(int v, int ow);
    if (v < 0) return 0;
    if (v > (1 << ow) - 1) return (1 << ow) - 1;
    return v;
  endfunction

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive_cycle(int c);
    logic [11:0] sc;
    for (int k = 0; k < 4; k++) sc[k*3 +: 3] = 3'(field(c - k, k));
    stage_codes = sc;
    fine_code   = 4'(field(c - 4, 4));
    in_valid    = valid_of(c);
  endtask

  task automatic check_cycle(int c);
    int m = c - 5;
    if (m < 0) begin
      chk("R6 idle before first sample (wide)", int'(valid_w), 0);
      chk("R6 idle before first sample (narrow)", int'(valid_n), 0);
    end else if (m < N) begin
      int raw = raw_of(m);
      chk("R6 valid delay (wide)", int'(valid_w), int'(valid_of(m)));
      chk("R6 valid delay (narrow)", int'(valid_n), int'(valid_of(m)));
      // R1/R2/R5: staggered codes of sample m appear combined five cycles later
      if (raw < 0) chk("R3 floor (wide)", int'(word_w), limit(raw, 12));
      else         chk("R1/R2/R5 word (wide)", int'(word_w), limit(raw, 12));
      if (raw > 2047) chk("R4 ceiling (narrow)", int'(word_n), limit(raw, 11));
      else if (raw < 0) chk("R3 floor (narrow)", int'(word_n), limit(raw, 11));
      else chk("R1/R2/R5 word (narrow)", int'(word_n), limit(raw, 11));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 word in reset (wide)", int'(word_w), 0);
    chk("R8 valid in reset (wide)", int'(valid_w), 0);
    chk("R8 word in reset (narrow)", int'(word_n), 0);
    chk("R8 valid in reset (narrow)", int'(valid_n), 0);
    rst = 1'b0;
    for (int c = 0; c < N + 6; c++) begin
      check_cycle(c);
      drive_cycle(c);
      @(negedge clk);
    end
    // R7: fill the delay lines with full-scale samples, then reset over them
    stage_codes = '1;
    fine_code   = '1;
    in_valid    = 1'b1;
    repeat (3) @(negedge clk);
    rst         = 1'b1;
    stage_codes = '0;
    fine_code   = '0;
    in_valid    = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 7; i++) begin
      chk("R7 flushed word (wide)", int'(word_w), 0);
      chk("R7 flushed valid (wide)", int'(valid_w), 0);
      chk("R7 flushed word (narrow)", int'(word_n), 0);
      chk("R7 flushed valid (narrow)", int'(valid_n), 0);
      @(negedge clk);
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule